// File: doc/BRIEF.md
# Event-to-Counter Binding Table

This block keeps the association between a small fixed set of hardware event identifiers and the programmable performance counters that count them. Software programs a counter by writing its event-select value. The table records which counter that event is bound to, so that event pulses coming from the pipeline can be steered to the right counter. A combinational lookup port takes an event identifier and returns the bound counter together with a hit flag. A second combinational port answers, for any counter index, whether that counter counts cycles or retired instructions.

Event identifiers are 20 bits wide. Bits 19:16 hold a type and bits 15:0 a code. For cache-type events (type 1) the code splits into a cache id in bits 15:3, an operation id in bits 2:1 and a result id in bit 0. Only five identifiers are accepted, and the table has one entry for each of them. Each entry holds a valid bit and a counter index.

The write port has no back-pressure. A write is taken in every cycle that `wr_valid` is high, and its outcome comes back one cycle later on `wr_done` and `wr_err`. The lookup and query ports carry no handshake, and their answers reflect the table as it stood after the most recent clock edge.

Top module: `evmap_table`

## Requirements
- R1: After reset, and in the cycle after a cycle with `clr` high, no event hits (`lk_hit`=0, `lk_ctr`=0), `qry_cycles` is 1 only for counter 0, and `qry_instret` is 1 only for counter 2.
- R2: The accepted identifiers are 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data-translation read miss: cache id 3, op 0, result 1), 0x1001B (data-translation write miss: cache id 3, op 1, result 1) and 0x10021 (instruction-translation miss: cache id 4, op 0, result 1). A write of one of these identifiers to a valid, unbound-event counter binds it. From the next cycle, a lookup of that identifier returns `lk_hit`=1 and the counter index.
- R3: Only bits 19:0 of `wr_sel` name the event. A nonzero select value whose bits 19:0 are an accepted identifier binds that identifier whatever the upper bits hold.
- R4: A nonzero select value whose bits 19:0 are not an accepted identifier (including zero low bits with nonzero upper bits) reports `wr_err`=1 and leaves every entry unchanged.
- R5: Valid counter indices are 3 to 3+NUM_CTRS-1. A write naming any other index, zero select included, reports `wr_err`=1 and leaves every entry unchanged.
- R6: A write of select value zero to a valid counter removes every entry bound to that counter, leaves the other entries unchanged, and reports `wr_err`=0.
- R7: If the written event is already bound, the write reports `wr_err`=0 and the existing binding is kept.
- R8: `wr_done` is 1 exactly in the cycle after a cycle with `wr_valid` high. `wr_err` is valid in that cycle and 0 whenever `wr_done` is 0.
- R9: `qry_cycles` is 1 for counter 0 and for the counter bound to 0x00001. `qry_instret` is 1 for counter 2 and for the counter bound to 0x00002. Both are 0 for every other index.
- R10: `clr` takes priority over a write in the same cycle. The table ends empty, while the write is still reported on `wr_done`/`wr_err`.
- R11: One counter may hold several events at once. Each bound event looks up to that counter.
- R12: A lookup of an identifier outside the accepted set never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all bindings |
| wr_valid | input | 1 | Event-select write strobe |
| wr_ctr | input | CTR_W (4) | Counter index being written |
| wr_sel | input | SEL_W (64) | Event-select value |
| wr_done | output | 1 | Write outcome valid (one cycle after the strobe) |
| wr_err | output | 1 | Write was rejected |
| lk_event | input | 20 | Event identifier to look up |
| lk_hit | output | 1 | Identifier is bound |
| lk_ctr | output | CTR_W (4) | Bound counter, 0 when unbound |
| qry_ctr | input | CTR_W (4) | Counter index being queried |
| qry_cycles | output | 1 | Counter counts cycles |
| qry_instret | output | 1 | Counter counts retired instructions |

## Verification
The bench sweeps every counter index, valid and invalid, against every accepted identifier and several near-miss identifiers. After each write it compares every lookup and every query against a bench model. The corner cases it targets are these:
- A rebind of an already-bound event: a design that overwrote the entry would move the lookup to the later counter.
- A zero-select write to a counter holding several events: a design that removed only one entry would leave a stale hit.
- Select values with stray upper bits, or with zero low bits: a design that decoded the whole value, or treated the value as zero, would bind wrongly or fail to report the error.
- A clear that arrives together with a write: a design that let the write win would leave a binding behind.

// File: rtl/evmap_pkg.sv
package evmap_pkg;
  localparam int EVT_W      = 20;
  localparam int NUM_SLOTS  = 5;
  localparam int FIRST_PROG = 3;

  localparam int SLOT_CYC     = 0;
  localparam int SLOT_INS     = 1;
  localparam int SLOT_DXL_RD  = 2;
  localparam int SLOT_DXL_WR  = 3;
  localparam int SLOT_IXL     = 4;

  typedef logic [NUM_SLOTS-1:0] slot_vec_t;

  // Compose a cache-type event: type 1, id/op/result packed into the code.
  function automatic logic [EVT_W-1:0] cache_evt(input int id, input int op, input int res);
    logic [15:0] code;
    code = (16'(id) << 3) | (16'(op) << 1) | 16'(res);
    return {4'h1, code};
  endfunction

  function automatic logic [EVT_W-1:0] slot_event(input int s);
    case (s)
      SLOT_CYC:    return 20'h00001;
      SLOT_INS:    return 20'h00002;
      SLOT_DXL_RD: return cache_evt(3, 0, 1);
      SLOT_DXL_WR: return cache_evt(3, 1, 1);
      default:     return cache_evt(4, 0, 1);
    endcase
  endfunction
endpackage

// File: rtl/evmap_decode.sv
module evmap_decode
  import evmap_pkg::*;
(
  input  logic [EVT_W-1:0] evt_i,
  output slot_vec_t        hit_o
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign hit_o[i] = (evt_i == slot_event(i));
  end
endmodule

// File: rtl/evmap_entry.sv
module evmap_entry #(
  parameter int CTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic             drop_en,
  input  logic [CTR_W-1:0] set_ctr,
  output logic             valid_o,
  output logic [CTR_W-1:0] ctr_o
);
  // The index is held at zero while invalid so readers may OR entries together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      ctr_o   <= '0;
    end else if (clr) begin
      valid_o <= 1'b0;
      ctr_o   <= '0;
    end else if (set_en) begin
      valid_o <= 1'b1;
      ctr_o   <= set_ctr;
    end else if (drop_en) begin
      valid_o <= 1'b0;
      ctr_o   <= '0;
    end
  end
endmodule

// File: rtl/evmap_query.sv
module evmap_query
  import evmap_pkg::*;
#(
  parameter int CTR_W = 4
) (
  input  slot_vec_t                         ent_valid,
  input  logic [NUM_SLOTS-1:0][CTR_W-1:0]   ent_ctr,
  input  logic [CTR_W-1:0]                  qry_ctr,
  output logic                              qry_cycles,
  output logic                              qry_instret
);
  localparam logic [CTR_W-1:0] FIXED_CYC = CTR_W'(0);
  localparam logic [CTR_W-1:0] FIXED_INS = CTR_W'(2);

  always_comb begin
    qry_cycles  = (qry_ctr == FIXED_CYC) ||
                  (ent_valid[SLOT_CYC] && ent_ctr[SLOT_CYC] == qry_ctr);
    qry_instret = (qry_ctr == FIXED_INS) ||
                  (ent_valid[SLOT_INS] && ent_ctr[SLOT_INS] == qry_ctr);
  end
endmodule

// File: rtl/evmap_table.sv
module evmap_table
  import evmap_pkg::*;
#(
  parameter  int NUM_CTRS = 8,
  parameter  int SEL_W    = 64,
  localparam int CTR_W    = $clog2(FIRST_PROG + NUM_CTRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_valid,
  input  logic [CTR_W-1:0] wr_ctr,
  input  logic [SEL_W-1:0] wr_sel,
  output logic             wr_done,
  output logic             wr_err,
  input  logic [EVT_W-1:0] lk_event,
  output logic             lk_hit,
  output logic [CTR_W-1:0] lk_ctr,
  input  logic [CTR_W-1:0] qry_ctr,
  output logic             qry_cycles,
  output logic             qry_instret
);
  localparam int               LIM     = FIRST_PROG + NUM_CTRS;
  localparam logic [CTR_W:0]   LIM_V   = (CTR_W+1)'(LIM);
  localparam logic [CTR_W:0]   FIRST_V = (CTR_W+1)'(FIRST_PROG);

  slot_vec_t                       wr_slot, lk_slot, lk_match;
  slot_vec_t                       ent_valid, set_en, drop_en;
  logic [NUM_SLOTS-1:0][CTR_W-1:0] ent_ctr;
  logic                            ctr_ok, sel_zero, known, reject;

  evmap_decode u_wdec (.evt_i(wr_sel[EVT_W-1:0]), .hit_o(wr_slot));
  evmap_decode u_ldec (.evt_i(lk_event),          .hit_o(lk_slot));

  always_comb begin
    ctr_ok   = ({1'b0, wr_ctr} >= FIRST_V) && ({1'b0, wr_ctr} < LIM_V);
    sel_zero = (wr_sel == '0);
    known    = |wr_slot;
    reject   = !ctr_ok || (!sel_zero && !known);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
    assign set_en[i]  = wr_valid && !reject && !sel_zero && wr_slot[i] && !ent_valid[i];
    assign drop_en[i] = wr_valid && !reject && sel_zero && ent_valid[i] &&
                        (ent_ctr[i] == wr_ctr);

    evmap_entry #(.CTR_W(CTR_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .set_en  (set_en[i]),
      .drop_en (drop_en[i]),
      .set_ctr (wr_ctr),
      .valid_o (ent_valid[i]),
      .ctr_o   (ent_ctr[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_done <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      wr_done <= wr_valid;
      wr_err  <= wr_valid && reject;
    end
  end

  always_comb begin
    lk_match = lk_slot & ent_valid;
    lk_hit   = |lk_match;
    lk_ctr   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (lk_match[i]) lk_ctr = lk_ctr | ent_ctr[i];
    end
  end

  evmap_query #(.CTR_W(CTR_W)) u_qry (
    .ent_valid   (ent_valid),
    .ent_ctr     (ent_ctr),
    .qry_ctr     (qry_ctr),
    .qry_cycles  (qry_cycles),
    .qry_instret (qry_instret)
  );
endmodule

// File: rtl/evmap_table_chk.sv
module evmap_table_chk
  import evmap_pkg::*;
#(
  parameter  int NUM_CTRS = 8,
  parameter  int SEL_W    = 64,
  localparam int CTR_W    = $clog2(FIRST_PROG + NUM_CTRS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             wr_valid,
  input logic [CTR_W-1:0] wr_ctr,
  input logic [SEL_W-1:0] wr_sel,
  input logic             wr_done,
  input logic             wr_err,
  input logic [EVT_W-1:0] lk_event,
  input logic             lk_hit,
  input logic [CTR_W-1:0] lk_ctr,
  input logic [CTR_W-1:0] qry_ctr,
  input logic             qry_cycles,
  input logic             qry_instret
);
  localparam int LIM = FIRST_PROG + NUM_CTRS;

  logic ctr_in_range;
  assign ctr_in_range = (int'(wr_ctr) >= FIRST_PROG) && (int'(wr_ctr) < LIM);

  // R1
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lk_hit);

  // R5
  bad_ctr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !ctr_in_range |=> wr_done && wr_err);

  // R6
  zero_sel_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && ctr_in_range && wr_sel == '0 |=> wr_done && !wr_err);

  // R8
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_done && !wr_err);

  // R7
  keep_binding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !clr && !(wr_valid && wr_sel == '0)) ##1 $stable(lk_event)
      |-> lk_hit && $stable(lk_ctr));

  // R2
  hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (int'(lk_ctr) >= FIRST_PROG) && (int'(lk_ctr) < LIM));

  // R9
  fixed_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_ctr == CTR_W'(0) |-> qry_cycles) and (qry_ctr == CTR_W'(2) |-> qry_instret));
endmodule

bind evmap_table evmap_table_chk #(.NUM_CTRS(NUM_CTRS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_ctr(wr_ctr),
  .wr_sel(wr_sel), .wr_done(wr_done), .wr_err(wr_err), .lk_event(lk_event),
  .lk_hit(lk_hit), .lk_ctr(lk_ctr), .qry_ctr(qry_ctr), .qry_cycles(qry_cycles),
  .qry_instret(qry_instret)
);

// File: tb/evmap_table_tb.sv
`timescale 1ns/1ps
module evmap_table_tb;
  localparam int NC = 8;
  localparam int CW = $clog2(3 + NC);
  localparam int NI = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, wr_valid = 1'b0;
  logic [CW-1:0] wr_ctr = '0, qry_ctr = '0;
  logic [63:0] wr_sel = '0;
  logic [19:0] lk_event = '0;
  logic wr_done, wr_err, lk_hit, qry_cycles, qry_instret;
  logic [CW-1:0] lk_ctr;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [19:0] ev [5] = '{20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021};
  bit       mv [5];
  int       mc [5];

  always #2 clk = ~clk;

  evmap_table #(.NUM_CTRS(NC), .SEL_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_ctr(wr_ctr),
    .wr_sel(wr_sel), .wr_done(wr_done), .wr_err(wr_err), .lk_event(lk_event),
    .lk_hit(lk_hit), .lk_ctr(lk_ctr), .qry_ctr(qry_ctr), .qry_cycles(qry_cycles),
    .qry_instret(qry_instret)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int slot_of(input logic [19:0] e);
    for (int s = 0; s < 5; s++) if (ev[s] == e) return s;
    return -1;
  endfunction

  task automatic check_tables(input string tag);
    for (int s = 0; s < 5; s++) begin
      lk_event = ev[s];
      #0.5;
      chk(tag, lk_hit, mv[s], $sformatf("hit slot %0d", s));
      chk(tag, lk_ctr, mv[s] ? mc[s] : 0, $sformatf("ctr slot %0d", s));
    end
    lk_event = 20'h10018; // R12: near miss of an accepted id
    #0.5;
    chk("R12", lk_hit, 0, "hit on unlisted id");
    for (int q = 0; q < NI; q++) begin
      qry_ctr = CW'(q);
      #0.5;
      chk({tag, "/R9"}, qry_cycles,  (q == 0) || (mv[0] && mc[0] == q), $sformatf("cycles q=%0d", q));
      chk({tag, "/R9"}, qry_instret, (q == 2) || (mv[1] && mc[1] == q), $sformatf("instret q=%0d", q));
    end
  endtask

  task automatic do_write(input int c, input logic [63:0] sel, input bit with_clr, input string tag);
    bit ok, exp_err;
    int s;
    @(negedge clk);
    wr_valid = 1'b1; wr_ctr = CW'(c); wr_sel = sel; clr = with_clr;
    @(negedge clk);
    wr_valid = 1'b0; clr = 1'b0;
    s = slot_of(sel[19:0]);
    ok = (c >= 3) && (c < 3 + NC);
    exp_err = !ok || (sel != 0 && s < 0);
    chk("R8", wr_done, 1, "wr_done after strobe");
    chk(tag, wr_err, exp_err, "wr_err");
    if (with_clr) begin
      for (int k = 0; k < 5; k++) mv[k] = 0;
    end else if (!exp_err) begin
      if (sel == 0) begin
        for (int k = 0; k < 5; k++) if (mv[k] && mc[k] == c) mv[k] = 0;
      end else if (!mv[s]) begin
        mv[s] = 1; mc[s] = c;
      end
    end
    @(negedge clk);
    chk("R8", wr_done, 0, "wr_done idle");
    chk("R8", wr_err, 0, "wr_err idle");
    check_tables(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] sweep [9];
    sweep = '{64'h1, 64'h2, 64'h10019, 64'h1001B, 64'h10021,
              64'h3, 64'h10018, 64'h20001, 64'h1_0000_0000};
    for (int k = 0; k < 5; k++) begin mv[k] = 0; mc[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", wr_done, 0, "wr_done after reset");
    check_tables("R1");

    // R5: every out-of-range index, with a good event and with zero
    for (int c = 0; c < NI; c++) begin
      if (c < 3 || c >= 3 + NC) begin
        do_write(c, 64'h1, 0, "R5");
        do_write(c, 64'h0, 0, "R5");
      end
    end
    // R3 upper bits ignored, R4 rejections
    do_write(4, 64'hABCD_0000_0000_0001, 0, "R3");
    do_write(5, 64'h0000_0001_0000_0000, 0, "R4");
    do_write(5, 64'h0000_0000_0010_0000, 0, "R4");
    do_write(5, 64'h1001A, 0, "R4");
    // R11 several events on one counter, R7 rebind kept
    do_write(4, 64'h10019, 0, "R11");
    do_write(10, 64'h1001B, 0, "R2");
    do_write(6, 64'h1, 0, "R7");
    // R6 zero removes all bindings of counter 4 only
    do_write(4, 64'h0, 0, "R6");
    // full sweep of valid counters by events
    for (int c = 3; c < 3 + NC; c++)
      for (int k = 0; k < 9; k++)
        do_write(c, sweep[k], 0, (k < 5) ? "R7" : "R4");
    check_tables("R11");
    for (int c = 3 + NC - 1; c >= 3; c--) do_write(c, 64'h0, 0, "R6");
    // R10 clear wins over a same-cycle write
    do_write(7, 64'h2, 0, "R2");
    do_write(8, 64'h10021, 1, "R10");
    do_write(9, 64'h10021, 0, "R2");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    for (int k = 0; k < 5; k++) mv[k] = 0;
    check_tables("R1");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule